// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that runs from a slow tick clock of about 32 kHz. Software uses a small 16-bit register window to program a timeout in half-second steps and to start the countdown. After that it must prove it is alive at regular intervals. It does this by writing a two-word key to the service register, and only a correct pair reloads the countdown. If the countdown runs out, the block drives a fixed-width reset pulse and records the cause in a status register. That register survives the resulting system reset.

Software can also force a reset through the control register. An optional suspend setting holds the countdown while the chip is in a low-power state. A boot-time power-down counter pulses an active-low interrupt line once, unless software switches it off first. Once the countdown is started it cannot be stopped, and the suspend choice can be made only once after each reset.

Top module: `keyed_wdog`

## Requirements
- R1: After `rst_por`, a read returns 0x0010 at control (offset 0x0), 0x0010 at status (0x4) and 0x0001 at misc (0x8). At that point both reset outputs are low and `wdog_int_n` is high. `bus_rdata` takes the addressed value on the clock edge where `bus_re` is high.
- R2: With control bits 15:8 holding N, the countdown expires (N+1)·HALF_TICKS clock cycles after it loads. A load happens on the write that first sets control bit 2, and on each completed service. After expiry exactly one reset pulse is produced, and the countdown halts until the next reset.
- R3: A reload happens only when a write of 0xAAAA to the service register (0x2) directly follows a write of 0x5555 to that register. Any other value written there cancels the pending key. A repeated 0x5555 keeps the key pending.
- R4: Software cannot clear the enable bit (control bit 2) once it is set. Only `rst_sys` or `rst_por` clears it.
- R5: The suspend bit (control bit 0) takes only the first control write after a reset. While it is 1 and `lp_mode` is high, the countdown pauses.
- R6: A timeout sets the status register to 0x0002, and a software reset sets it to 0x0001. `rst_por` sets it to 0x0010, and `rst_sys` leaves it unchanged.
- R7: A control write with bit 4 at 0 produces a software reset pulse on `sys_rst_o`, but only when the enable bit is set after that write. With enable clear, such a write produces no pulse. Bit 4 always reads 1.
- R8: Every reset pulse is exactly RST_CYCLES cycles wide. A timeout pulse appears on `ext_rst_o` when control bit 3 is 1, and on `sys_rst_o` otherwise. The two outputs are never high together.
- R9: After a reset, `wdog_int_n` goes low for exactly one cycle about PDC_CYCLES cycles later. A misc write with bit 0 at 0 disables this, after which misc reads 0 and cannot be set again.
- R10: Rewriting the timeout field while the countdown runs does not change the count in progress. The new value is used at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow tick clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high; also clears status |
| rst_sys | input | 1 | System reset, synchronous, active high; keeps status |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| lp_mode | input | 1 | Low-power state indication |
| sys_rst_o | output | 1 | System reset request pulse |
| ext_rst_o | output | 1 | External reset pin pulse |
| wdog_int_n | output | 1 | Active-low power-down interrupt |

## Verification
The assertions check several properties on every clock cycle. The enable bit never falls outside reset, and the suspend bit never changes once it is locked. A reload never occurs without the armed key state, and the countdown holds still while suspended. Each expiry is a single-cycle event, the two reset outputs are never both high, every pulse has the parameter width, and the interrupt is low for only one cycle. The bench scenarios are needed for the rest. They check the absolute expiry time for different field values, the cancelling key patterns and a delayed timeout rewrite. They also cover the end-to-end suspend delay, how the status register behaves across the two resets, and the disabled power-down counter.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int TMO_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_MISC = 4'h8;

  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  // control bit positions
  localparam int CB_SUSP    = 0;
  localparam int CB_EN      = 2;
  localparam int CB_RSEL    = 3;
  localparam int CB_SWRST_N = 4;
  localparam int CB_TMO_LO  = 8;

  // status bit positions
  localparam int SB_SW  = 0;
  localparam int SB_TMO = 1;
  localparam int SB_POR = 4;

  typedef enum logic {KS_IDLE, KS_ARMED} keystate_t;

  typedef struct packed {
    logic [TMO_W-1:0] tmo;
    logic             rsel;
    logic             en;
    logic             susp;
  } ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int PDC_CYCLES = 524288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  status_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic              arm_load_o,
  output logic              swrst_o,
  output logic              svc_wr_o,
  output logic              int_n_o
);
  localparam int PDC_W = $clog2(PDC_CYCLES + 1);

  ctrl_t            ctrl_q;
  logic             susp_lock_q;
  logic             arm_q;
  logic             swrst_q;
  logic             pdc_en_q;
  logic             pdc_fired_q;
  logic             int_n_q;
  logic [PDC_W-1:0] pdc_cnt_q;
  logic [REG_W-1:0] rdata_q;

  logic wr_ctrl, wr_misc, en_after;
  assign wr_ctrl  = wr_en_i && (addr_i == OFF_CTRL);
  assign wr_misc  = wr_en_i && (addr_i == OFF_MISC);
  assign svc_wr_o = wr_en_i && (addr_i == OFF_SVC);
  assign en_after = ctrl_q.en | wdata_i[CB_EN];

  // control register with sticky enable and write-once suspend
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      susp_lock_q <= 1'b0;
      arm_q       <= 1'b0;
      swrst_q     <= 1'b0;
    end else begin
      arm_q   <= 1'b0;
      swrst_q <= 1'b0;
      if (wr_ctrl) begin
        ctrl_q.tmo  <= wdata_i[CB_TMO_LO +: TMO_W];
        ctrl_q.rsel <= wdata_i[CB_RSEL];
        ctrl_q.en   <= en_after;
        if (!susp_lock_q) begin
          ctrl_q.susp <= wdata_i[CB_SUSP];
          susp_lock_q <= 1'b1;
        end
        arm_q   <= wdata_i[CB_EN] && !ctrl_q.en;
        swrst_q <= en_after && !wdata_i[CB_SWRST_N];
      end
    end
  end

  // boot power-down counter driving the interrupt line
  always_ff @(posedge clk) begin
    if (rst) begin
      pdc_en_q    <= 1'b1;
      pdc_fired_q <= 1'b0;
      pdc_cnt_q   <= PDC_W'(PDC_CYCLES - 1);
      int_n_q     <= 1'b1;
    end else begin
      int_n_q <= 1'b1;
      if (wr_misc && !wdata_i[0]) pdc_en_q <= 1'b0;
      if (pdc_en_q && !pdc_fired_q) begin
        if (pdc_cnt_q == '0) begin
          int_n_q     <= 1'b0;
          pdc_fired_q <= 1'b1;
        end else begin
          pdc_cnt_q <= pdc_cnt_q - 1'b1;
        end
      end
    end
  end

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        OFF_CTRL: rdata_q <= {ctrl_q.tmo, 3'b000, 1'b1, ctrl_q.rsel,
                              ctrl_q.en, 1'b0, ctrl_q.susp};
        OFF_STAT: rdata_q <= status_i;
        OFF_MISC: rdata_q <= {{(REG_W-1){1'b0}}, pdc_en_q};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o    = rdata_q;
  assign ctrl_o     = ctrl_q;
  assign arm_load_o = arm_q;
  assign swrst_o    = swrst_q;
  assign int_n_o    = int_n_q;

  p_en_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.en |=> ctrl_q.en);
  p_susp_once_r5: assert property (@(posedge clk) disable iff (rst)
    susp_lock_q |=> $stable(ctrl_q.susp) && susp_lock_q);
  p_swrst_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    swrst_q |-> ctrl_q.en);
  p_int_single_r9: assert property (@(posedge clk) disable iff (rst)
    !int_n_q |=> int_n_q);
endmodule

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [REG_W-1:0] data_i,
  output logic             fire_o
);
  keystate_t st_q;
  logic      fire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= KS_IDLE;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (wr_i) begin
        if (data_i == KEY_ARM) begin
          st_q <= KS_ARMED;
        end else begin
          if (st_q == KS_ARMED && data_i == KEY_FIRE) fire_q <= 1'b1;
          st_q <= KS_IDLE;
        end
      end
    end
  end

  assign fire_o = fire_q;

  p_fire_needs_arm_r3: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> $past(st_q) == KS_ARMED && $past(data_i) == KEY_FIRE && $past(wr_i));
  p_other_cancels_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_i && data_i != KEY_ARM && data_i != KEY_FIRE) |=> st_q == KS_IDLE && !fire_q);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import wdg_pkg::*;
#(
  parameter int HALF_TICKS = 16384
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             susp_i,
  input  logic             lp_i,
  output logic             expire_o
);
  localparam int PRE_W = $clog2(HALF_TICKS + 1);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(HALF_TICKS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [TMO_W-1:0] cnt_q;
  logic             done_q;
  logic             exp_q;
  logic             hold;

  assign hold = susp_i && lp_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        pre_q <= PRE_TOP;
        cnt_q <= tmo_i;
      end else if (run_i && !done_q && !hold) begin
        if (pre_q == '0) begin
          pre_q <= PRE_TOP;
          if (cnt_q == '0) begin
            done_q <= 1'b1;
            exp_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else begin
          pre_q <= pre_q - 1'b1;
        end
      end
    end
  end

  assign expire_o = exp_q;

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (susp_i && lp_i && !load_i) |=> $stable(pre_q) && $stable(cnt_q));
  p_expire_once_r2: assert property (@(posedge clk) disable iff (rst)
    exp_q |=> !exp_q && done_q);
  p_halted_r2: assert property (@(posedge clk) disable iff (rst)
    (done_q && !load_i) |=> $stable(cnt_q) && !exp_q);
endmodule

// File: rtl/wdg_rstpulse.sv
module wdg_rstpulse
  import wdg_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             tmo_exp_i,
  input  logic             sw_i,
  input  logic             rsel_i,
  output logic             sys_o,
  output logic             ext_o,
  output logic [REG_W-1:0] status_o
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic             sys_q, ext_q;
  logic [PW-1:0]    cnt_q;
  logic [REG_W-1:0] status_q;
  logic             trig, to_ext, active;

  assign trig   = tmo_exp_i || sw_i;
  assign to_ext = tmo_exp_i && rsel_i;
  assign active = sys_q || ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q <= 1'b0;
      ext_q <= 1'b0;
      cnt_q <= '0;
    end else if (trig && !active) begin
      sys_q <= !to_ext;
      ext_q <= to_ext;
      cnt_q <= PW'(RST_CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      sys_q <= 1'b0;
      ext_q <= 1'b0;
    end
  end

  // cause record: cleared only by power-on reset
  always_ff @(posedge clk) begin
    if (por) begin
      status_q         <= '0;
      status_q[SB_POR] <= 1'b1;
    end else if (tmo_exp_i) begin
      status_q         <= '0;
      status_q[SB_TMO] <= 1'b1;
    end else if (sw_i) begin
      status_q        <= '0;
      status_q[SB_SW] <= 1'b1;
    end
  end

  assign sys_o    = sys_q;
  assign ext_o    = ext_q;
  assign status_o = status_q;

  // width checker
  logic [PW:0] len_q;
  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else     len_q <= active ? len_q + 1'b1 : '0;
  end

  p_one_line_r8: assert property (@(posedge clk) disable iff (rst)
    !(sys_q && ext_q));
  p_width_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> len_q == (PW+1)'(RST_CYCLES));
  p_stat_tmo_r6: assert property (@(posedge clk) disable iff (rst)
    tmo_exp_i |=> status_q[SB_TMO]);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdg_pkg::*;
#(
  parameter int HALF_TICKS = 16384,
  parameter int RST_CYCLES = 4,
  parameter int PDC_CYCLES = 524288
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_sys,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              lp_mode,
  output logic              sys_rst_o,
  output logic              ext_rst_o,
  output logic              wdog_int_n
);
  logic             rst_any;
  ctrl_t            ctrl;
  logic             arm_load, swrst, svc_wr, fire, expire;
  logic [REG_W-1:0] status;

  assign rst_any = rst_por | rst_sys;

  wdg_regs #(.PDC_CYCLES(PDC_CYCLES)) u_regs (
    .clk(clk), .rst(rst_any), .wr_en_i(bus_we), .rd_en_i(bus_re),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .status_i(status),
    .rdata_o(bus_rdata), .ctrl_o(ctrl), .arm_load_o(arm_load),
    .swrst_o(swrst), .svc_wr_o(svc_wr), .int_n_o(wdog_int_n)
  );

  wdg_keyseq u_keyseq (
    .clk(clk), .rst(rst_any), .wr_i(svc_wr), .data_i(bus_wdata), .fire_o(fire)
  );

  wdg_countdown #(.HALF_TICKS(HALF_TICKS)) u_count (
    .clk(clk), .rst(rst_any), .run_i(ctrl.en), .load_i(arm_load | fire),
    .tmo_i(ctrl.tmo), .susp_i(ctrl.susp), .lp_i(lp_mode), .expire_o(expire)
  );

  wdg_rstpulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst(rst_any), .por(rst_por), .tmo_exp_i(expire),
    .sw_i(swrst), .rsel_i(ctrl.rsel), .sys_o(sys_rst_o), .ext_o(ext_rst_o),
    .status_o(status)
  );
endmodule

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
  localparam int H   = 8;
  localparam int RC  = 4;
  localparam int PDC = 40;

  logic        clk = 1'b0;
  logic        rst_por = 1'b1, rst_sys = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0, lp_mode = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sys_rst_o, ext_rst_o, wdog_int_n;

  keyed_wdog #(.HALF_TICKS(H), .RST_CYCLES(RC), .PDC_CYCLES(PDC)) i_keyed_wdog (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .bus_we(bus_we),
    .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lp_mode(lp_mode), .sys_rst_o(sys_rst_o),
    .ext_rst_o(ext_rst_o), .wdog_int_n(wdog_int_n)
  );

  always #2ns clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int last_p = 0;

  typedef struct { bit ext; int lo; int hi; string req; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string req, input int act, input int expv, input string what);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    last_p = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [15:0] e, input string req, input string what);
    logic [15:0] d;
    rd(a, d);
    chk(req, int'(d), int'(e), what);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_sys = 1'b1;
    idle(3);
    rst_sys = 1'b0;
  endtask

  task automatic expect_pulse(input bit ext, input int at, input string req);
    exp_t e;
    e.ext = ext; e.lo = at - 1; e.hi = at + 1; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic count_int_low(input int n, output int lows);
    lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (!wdog_int_n) lows++;
    end
  endtask

  // scoreboard monitor
  bit act = 0, line = 0;
  int st = 0, w = 0;
  always @(negedge clk) begin
    if (sys_rst_o || ext_rst_o) begin
      if (!act) begin act = 1; st = cyc; line = ext_rst_o; w = 0; end
      w++;
    end else if (act) begin
      act = 0;
      if (sb_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 unexpected pulse at cycle %0d: actual ext=%0d expected none", st, line);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, int'(line), int'(e.ext), "pulse line (R8)");
        chk("R8", w, RC, "pulse width");
        n_chk++;
        if (st < e.lo || st > e.hi) begin
          n_bad++;
          $display("FAIL %s pulse start: actual %0d expected %0d..%0d", e.req, st, e.lo, e.hi);
        end
      end
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lows;
    logic [15:0] d;
    // R1 reset state
    idle(3);
    rst_por = 1'b0;
    chk("R1", int'(sys_rst_o), 0, "sys_rst_o after por");
    chk("R1", int'(ext_rst_o), 0, "ext_rst_o after por");
    chk("R1", int'(wdog_int_n), 1, "int_n after por");
    rd_chk(4'h0, 16'h0010, "R1", "ctrl reset value");
    rd_chk(4'h4, 16'h0010, "R1", "status after por (R6)");
    rd_chk(4'h8, 16'h0001, "R1", "misc reset value");
    // R9 one-cycle interrupt pulse
    count_int_low(60, lows);
    chk("R9", lows, 1, "int_n low cycles");

    // R2 timeout N=1 on sys line, halts after one pulse
    wr(4'h0, 16'h0110);
    wr(4'h0, 16'h0114);
    expect_pulse(1'b0, last_p + 2 + 2*H, "R2");
    idle(70);
    rd_chk(4'h4, 16'h0002, "R6", "status after timeout");
    sys_reset();
    rd_chk(4'h4, 16'h0002, "R6", "status kept over rst_sys");
    rd_chk(4'h0, 16'h0010, "R4", "enable cleared by rst_sys");

    // R3 key sequences, R4 sticky enable, R10 delayed field
    wr(4'h0, 16'h0314);
    repeat (3) begin
      idle(10);
      wr(4'h2, 16'h5555);
      wr(4'h2, 16'hAAAA);
    end
    idle(10);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    begin
      int ps;
      ps = last_p;
      wr(4'h0, 16'h0110);
      rd_chk(4'h0, 16'h0114, "R4", "enable survives clearing write");
      wr(4'h2, 16'h5555);
      wr(4'h2, 16'h1234);
      wr(4'h2, 16'hAAAA);
      wr(4'h2, 16'hAAAA);
      expect_pulse(1'b0, ps + 2 + 4*H, "R3");
    end
    idle(60);
    sys_reset();

    // R10 new field used at next service
    wr(4'h0, 16'h0314);
    wr(4'h0, 16'h0114);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    expect_pulse(1'b0, last_p + 2 + 2*H, "R10");
    idle(40);
    sys_reset();

    // R5 write-once suspend and pause in low power
    wr(4'h0, 16'h0111);
    wr(4'h0, 16'h0110);
    rd_chk(4'h0, 16'h0111, "R5", "suspend bit locked");
    wr(4'h0, 16'h0115);
    lp_mode = 1'b1;
    idle(50);
    chk("R5", int'(sys_rst_o), 0, "no expiry while suspended");
    lp_mode = 1'b0;
    expect_pulse(1'b0, cyc + 1 + 2*H, "R5");
    idle(40);
    sys_reset();

    // R8 timeout routed to external line
    wr(4'h0, 16'h0018);
    wr(4'h0, 16'h001C);
    expect_pulse(1'b1, last_p + 2 + H, "R8");
    idle(30);
    rd_chk(4'h4, 16'h0002, "R6", "status after external timeout");
    sys_reset();

    // R7 software reset
    wr(4'h0, 16'h0000);
    idle(10);
    rd_chk(4'h4, 16'h0002, "R7", "no software reset while disabled");
    wr(4'h0, 16'h0314);
    wr(4'h0, 16'h0004);
    expect_pulse(1'b0, last_p + 1, "R7");
    idle(8);
    rd_chk(4'h4, 16'h0001, "R7", "status after software reset");
    sys_reset();

    // R9 power-down counter disabled
    wr(4'h8, 16'h0000);
    rd_chk(4'h8, 16'h0000, "R9", "misc after disable");
    count_int_low(60, lows);
    chk("R9", lows, 0, "int_n low cycles when disabled");
    wr(4'h8, 16'h0001);
    rd_chk(4'h8, 16'h0000, "R9", "misc cannot be re-enabled");

    // R6 power-on reset clears cause
    @(negedge clk); rst_por = 1'b1;
    idle(3);
    rst_por = 1'b0;
    rd_chk(4'h4, 16'h0010, "R6", "status after second por");

    idle(5);
    if (sb_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2 missing pulses: actual %0d pending expected 0", sb_q.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule